// File: doc/BRIEF.md
# Parallel PRBS Bit-Error Checker

This block checks a pseudo-random test stream that reaches it already deserialized, `WORD_W` bits per clock. It keeps its own copy of the sequence in a reference history register. On every valid word, that register steps forward by `WORD_W` serial positions through unrolled feedback logic. The received word is XORed with the expected word. A ones-count over the mismatch vector gives the number of wrong bits in that word, and this number is added into a saturating error total in a single step.

The checker starts in acquire mode. In this mode the reference history is reloaded from the received bits, so the reference falls into step with whatever phase the incoming stream has. Once a programmable number of consecutive valid words match the prediction, the checker locks. From then on the reference runs freely and errors are counted. The counter can be cleared without losing lock. A resync input sends the checker back to acquire mode. Word alignment across bit rotations is outside this block.

Top module: `prbs_word_checker`

## Requirements
- R1: While reset is held and right after it, `err_count` is 0, `word_err` is 0 and `locked` is 0.
- R2: Bit 0 of `in_word` is the earliest serial bit. With default parameters the sequence obeys b(k) = b(k-7) XOR b(k-6). On each locked valid word the reference moves ahead by exactly `WORD_W` serial steps.
- R3: While unlocked, each valid word reloads the reference history with the received bits and adds nothing to `err_count`. `locked` rises on the edge that accepts the `LOCK_WORDS`-th consecutive valid word that matches the prediction (default 4). Any mismatching valid word restarts the run.
- R4: On a locked valid word, `err_count` grows by the number of bit positions where `in_word` differs from the expected word. Several wrong bits in one word all count.
- R5: On the edge after a locked valid word, `word_err` is 1 if that word had at least one wrong bit and 0 otherwise. It is 0 after unlocked or invalid cycles.
- R6: `err_count` saturates at 2^`CNT_W`-1 (65535 by default) and never wraps.
- R7: `clr_count` forces `err_count` to 0 on the next edge, even over an error word in the same cycle, and leaves `locked` unchanged.
- R8: `resync` drops `locked` on the next edge and restarts acquisition. A new lock then needs a fresh run of matching words.
- R9: The reference history never holds the stuck state (all zeros for XOR feedback, all ones for XNOR feedback). Reset and any load that would produce it give instead the stuck state with the most recent bit inverted (0000001 by default). As a result, an all-zero input never achieves lock.
- R10: Cycles with `in_valid` low change neither the reference, the count, the lock run nor the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_word` as carrying stream data this cycle |
| in_word | input | WORD_W | Received bits, bit 0 earliest |
| clr_count | input | 1 | Zeroes the error total |
| resync | input | 1 | Returns the checker to acquire mode |
| err_count | output | CNT_W | Saturating total of bit errors while locked |
| word_err | output | 1 | Last locked valid word had at least one wrong bit |
| locked | output | 1 | Reference is aligned and errors are being counted |

## Verification
The assertions assume the following about the inputs. The incoming words are a true sequence from the same recurrence, cut on word boundaries with the earliest bit in position 0. Lock can only rise after a valid matching word. `resync` is asserted with `in_valid` low, so the word in that cycle carries no meaning. The bench builds its stream from its own copy of the recurrence. It corrupts words only by XOR masks applied after lock. It drives resync only in idle cycles. It feeds an all-zero stream only to show that lock never comes.

// File: rtl/prbs_chk_pkg.sv
`timescale 1ns/1ps
package prbs_chk_pkg;
  // Checker operating mode
  typedef enum logic {
    MODE_ACQ   = 1'b0,   // reference reloaded from received data
    MODE_TRACK = 1'b1    // reference free-running, errors counted
  } chk_mode_e;
endpackage

// File: rtl/prbs_ref_step.sv
`timescale 1ns/1ps
// Unrolled reference stepper: predicts WORD_W serial bits from the
// current history, and also builds the history that results from
// shifting the received bits in instead.
module prbs_ref_step #(
  parameter int WORD_W  = 8,
  parameter int LEN     = 7,
  parameter int TAP_A   = 7,
  parameter int TAP_B   = 6,
  parameter bit XNOR_FB = 1'b0
) (
  input  logic [LEN-1:0]    hist,       // bit 0 = most recent serial bit
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] exp_word,
  output logic [LEN-1:0]    hist_adv,
  output logic [LEN-1:0]    hist_seed
);

  // one serial step of feedback: b(k) = b(k-TAP_A) ^ b(k-TAP_B) (^1 for XNOR)
  function automatic logic feedback(input logic [LEN-1:0] h);
    return h[TAP_A-1] ^ h[TAP_B-1] ^ XNOR_FB;
  endfunction

  function automatic logic [LEN-1:0] shift_in(input logic [LEN-1:0] h, input logic b);
    return {h[LEN-2:0], b};
  endfunction

  logic [LEN-1:0] gen_h;
  logic [LEN-1:0] rx_h;

  always_comb begin
    gen_h = hist;
    rx_h  = hist;
    exp_word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      exp_word[i] = feedback(gen_h);
      gen_h       = shift_in(gen_h, exp_word[i]);
      rx_h        = shift_in(rx_h, rx_word[i]);
    end
    hist_adv  = gen_h;
    hist_seed = rx_h;
  end

endmodule

// File: rtl/prbs_err_tally.sv
`timescale 1ns/1ps
// Ones-count over the mismatch vector and saturating accumulator.
module prbs_err_tally #(
  parameter  int WORD_W = 8,
  parameter  int CNT_W  = 16,
  localparam int EW     = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              clr,
  input  logic [WORD_W-1:0] mism,
  output logic [EW-1:0]     word_errs,
  output logic [CNT_W-1:0]  err_count,
  output logic              word_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [EW-1:0] ones_in(input logic [WORD_W-1:0] v);
    logic [EW-1:0] c;
    c = '0;
    for (int i = 0; i < WORD_W; i++) c = c + EW'(v[i]);
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [EW-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  assign word_errs = ones_in(mism);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count <= '0;
      word_err  <= 1'b0;
    end else begin
      word_err <= count_en && (word_errs != '0);
      if (clr)           err_count <= '0;
      else if (count_en) err_count <= sat_add(err_count, word_errs);
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_count == '0)); // R7
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !clr) |=> (err_count == CNT_MAX)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_count >= $past(err_count))); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clr) |=> $stable(err_count)); // R3
  AST_FLAG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && word_errs == '0) |=> !word_err); // R5

endmodule

// File: rtl/prbs_lock_fsm.sv
`timescale 1ns/1ps
// Acquire/track control: counts consecutive clean words before lock.
module prbs_lock_fsm
  import prbs_chk_pkg::*;
#(
  parameter  int LOCK_WORDS = 4,
  localparam int RW         = $clog2(LOCK_WORDS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic resync,
  input  logic word_clean,
  output logic locked,
  output logic count_en,
  output logic load_from_rx
);

  chk_mode_e      mode;
  logic [RW-1:0]  run;

  assign locked       = (mode == MODE_TRACK);
  assign count_en     = valid && locked && !resync;
  assign load_from_rx = valid && (!locked || resync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_ACQ;
      run  <= '0;
    end else if (resync) begin
      mode <= MODE_ACQ;
      run  <= '0;
    end else if (valid && mode == MODE_ACQ) begin
      if (!word_clean) begin
        run <= '0;
      end else if (run == RW'(LOCK_WORDS - 1)) begin
        mode <= MODE_TRACK;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !resync) |=> locked); // R7
  AST_RESYNC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !locked); // R8
  AST_LOCK_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(valid && word_clean)); // R3

endmodule

// File: rtl/prbs_word_checker.sv
`timescale 1ns/1ps
// Parallel PRBS bit-error checker, top level.
module prbs_word_checker #(
  parameter int WORD_W     = 8,
  parameter int PRBS_LEN   = 7,
  parameter int TAP_A      = 7,
  parameter int TAP_B      = 6,
  parameter bit XNOR_FB    = 1'b0,
  parameter int CNT_W      = 16,
  parameter int LOCK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              clr_count,
  input  logic              resync,
  output logic [CNT_W-1:0]  err_count,
  output logic              word_err,
  output logic              locked
);

  localparam int EW = $clog2(WORD_W + 1);
  localparam logic [PRBS_LEN-1:0] STUCK     = {PRBS_LEN{XNOR_FB}};
  localparam logic [PRBS_LEN-1:0] SAFE_SEED = STUCK ^ PRBS_LEN'(1);

  function automatic logic [PRBS_LEN-1:0] legalize(input logic [PRBS_LEN-1:0] h);
    return (h == STUCK) ? SAFE_SEED : h;
  endfunction

  logic [PRBS_LEN-1:0] ref_hist;
  logic [PRBS_LEN-1:0] hist_adv, hist_seed;
  logic [WORD_W-1:0]   exp_word, mism;
  logic [EW-1:0]       word_errs;
  logic                count_en, load_from_rx;

  prbs_ref_step #(
    .WORD_W(WORD_W), .LEN(PRBS_LEN), .TAP_A(TAP_A), .TAP_B(TAP_B), .XNOR_FB(XNOR_FB)
  ) u_step (
    .hist(ref_hist), .rx_word(in_word), .exp_word(exp_word),
    .hist_adv(hist_adv), .hist_seed(hist_seed)
  );

  assign mism = in_word ^ exp_word;

  prbs_lock_fsm #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .resync(resync),
    .word_clean(word_errs == '0), .locked(locked),
    .count_en(count_en), .load_from_rx(load_from_rx)
  );

  prbs_err_tally #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .clr(clr_count),
    .mism(mism), .word_errs(word_errs), .err_count(err_count), .word_err(word_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ref_hist <= SAFE_SEED;
    else if (load_from_rx) ref_hist <= legalize(hist_seed);
    else if (count_en)     ref_hist <= legalize(hist_adv);
  end

  AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hist != STUCK); // R9
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ref_hist)); // R10

endmodule

// File: tb/prbs_word_checker_test.sv
`timescale 1ns/1ps
module prbs_word_checker_test;
  localparam int N   = 8;
  localparam int CW  = 16;
  localparam int LW  = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, in_valid, clr_count, resync;
  logic [N-1:0]  in_word;
  wire  [CW-1:0] err_count;
  wire           word_err, locked;

  prbs_word_checker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .clr_count(clr_count), .resync(resync),
    .err_count(err_count), .word_err(word_err), .locked(locked)
  );

  int checks = 0, failures = 0;

  // scoreboard queues
  int    q_cnt[$];
  bit    q_flag[$];
  bit    q_lk[$];
  string q_tag[$];

  // model state: histories in time order, last element is newest
  bit mh[$];
  bit src[$];
  int m_run = 0;
  bit m_lk  = 0;
  int m_cnt = 0;

  function automatic logic [N-1:0] predict(input bit h[$]);
    bit t[$];
    logic [N-1:0] w;
    t = h;
    for (int i = 0; i < N; i++) begin
      w[i] = t[t.size()-7] ^ t[t.size()-6];
      t.push_back(w[i]);
    end
    return w;
  endfunction

  function automatic void absorb(input logic [N-1:0] w);
    bit any;
    for (int i = 0; i < N; i++) begin
      mh.push_back(w[i]);
      void'(mh.pop_front());
    end
    any = 0;
    foreach (mh[k]) any |= mh[k];
    if (!any) mh = '{0, 0, 0, 0, 0, 0, 1};   // R9 substitute history
  endfunction

  function automatic logic [N-1:0] src_next();
    logic [N-1:0] w;
    for (int i = 0; i < N; i++) begin
      w[i] = src[0] ^ src[1];
      src.push_back(w[i]);
      void'(src.pop_front());
    end
    return w;
  endfunction

  task automatic drive(input bit v, input logic [N-1:0] w, input bit clr,
                       input bit rs, input string tag);
    logic [N-1:0] e;
    int errs;
    bit flag;
    @(negedge clk);
    in_valid = v; in_word = w; clr_count = clr; resync = rs;
    e = predict(mh);
    errs = 0;
    for (int i = 0; i < N; i++) if (w[i] != e[i]) errs++;
    flag = 0;
    if (rs) begin
      m_lk = 0; m_run = 0;
      if (v) absorb(w);
    end else if (v && !m_lk) begin
      if (errs == 0) begin
        m_run++;
        if (m_run == LW) begin m_lk = 1; m_run = 0; end
      end else m_run = 0;
      absorb(w);
    end else if (v && m_lk) begin
      flag = (errs != 0);
      m_cnt = (m_cnt + errs > MAXC) ? MAXC : m_cnt + errs;
      absorb(e);
    end
    if (clr) m_cnt = 0;
    q_cnt.push_back(m_cnt); q_flag.push_back(flag);
    q_lk.push_back(m_lk);   q_tag.push_back(tag);
  endtask

  // monitor: sample one unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_cnt.size() > 0) begin
        int c; bit f, l; string t;
        c = q_cnt.pop_front(); f = q_flag.pop_front();
        l = q_lk.pop_front();  t = q_tag.pop_front();
        checks++;
        if (err_count !== CW'(c) || word_err !== f || locked !== l) begin
          failures++;
          $display("FAIL %s: err_count=%0d exp %0d, word_err=%0b exp %0b, locked=%0b exp %0b",
                   t, err_count, c, word_err, f, locked, l);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_word = '0; clr_count = 0; resync = 0;
    mh  = '{0, 0, 0, 0, 0, 0, 1};
    src = '{1, 0, 1, 1, 0, 0, 1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;   // R1 reset state
    if (err_count !== '0 || word_err !== 1'b0 || locked !== 1'b0) begin
      failures++;
      $display("FAIL R1: cnt=%0d flag=%0b lock=%0b expected 0 0 0", err_count, word_err, locked);
    end
    rst_n = 1;

    // R9: an all-zero input must never lock
    for (int i = 0; i < 8; i++) drive(1, '0, 0, 0, "R9 zero stream");

    // R3: acquire on the true stream, lock after LW clean words
    for (int i = 0; i < 7; i++) drive(1, src_next(), 0, 0, "R3 acquire");

    // R2: tracking clean words
    for (int i = 0; i < 20; i++) drive(1, src_next(), 0, 0, "R2 tracking");

    // R10: idle cycles with garbage on the data lines
    for (int i = 0; i < 6; i++) begin
      drive(1, src_next(), 0, 0, "R10 valid");
      drive(0, 8'hA5, 0, 0, "R10 idle");
    end

    // R4 / R5: known error positions
    drive(1, src_next() ^ 8'h01, 0, 0, "R4 R5 single bit0");
    drive(1, src_next() ^ 8'h80, 0, 0, "R4 R5 single bit7");
    drive(1, src_next(), 0, 0, "R5 clean after error");
    drive(1, src_next() ^ 8'b1000_1001, 0, 0, "R4 three in one word");
    drive(1, src_next() ^ 8'hFF, 0, 0, "R4 whole word wrong");
    drive(0, 8'h00, 0, 0, "R5 idle after error");
    for (int i = 0; i < 3; i++) drive(1, src_next(), 0, 0, "R5 clean");

    // R7: clear keeps lock, clear beats same-cycle errors
    drive(1, src_next() ^ 8'h03, 1, 0, "R7 clear with error word");
    drive(1, src_next() ^ 8'h10, 0, 0, "R7 count after clear");
    drive(0, 8'h00, 1, 0, "R7 idle clear");
    drive(1, src_next(), 0, 0, "R7 lock kept");

    // R6: saturation
    for (int i = 0; i < 8200; i++) drive(1, src_next() ^ 8'hFF, 0, 0, "R6 saturate");
    drive(1, src_next(), 0, 0, "R6 hold at max");
    drive(0, 8'h00, 1, 0, "R6 clear from max");

    // R8: resync then reacquire
    drive(0, 8'h00, 0, 1, "R8 resync");
    drive(1, src_next() ^ 8'h04, 0, 0, "R8 unlocked error ignored");
    for (int i = 0; i < 6; i++) drive(1, src_next(), 0, 0, "R8 relock");
    drive(1, src_next() ^ 8'h22, 0, 0, "R8 counting again");
    drive(0, 8'h00, 0, 0, "R8 final idle");

    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule